// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a small 8-bit microcontroller core and tells the core which one to service next. Seven external pins pass through a synchronizer and an edge detector whose active edge software selects. Eight internal event pulses come from timers, serial units and the converter. A break request comes from the core, and a reset request is pending from the moment reset is released. Each of the fifteen maskable sources has a request latch and an enable bit. The core's interrupt-disable flag comes in as an input.

A fixed seventeen-level priority encoder picks the most urgent source that is allowed to interrupt. Its two vector byte addresses are presented all the time `irq_o` is high. The core pulses `ack` for one cycle to take the interrupt. In that cycle `accept_o` tells the core to set its disable flag, and at the closing clock edge the request latch of the accepted source is cleared. A small register port gives access to the request, enable and edge-polarity bits.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Out of reset, the request, enable and polarity registers read 0, and `irq_o` is high with `vec_lo` = 0xFFFC and `vec_hi` = 0xFFFD. This reset level stays pending until the first acknowledge.
- R2: A maskable source is pending toward the core only when its request bit is 1, its enable bit is 1 and `iflag` is 0. When `iflag` is 1 and neither reset nor break is pending, `irq_o` is 0.
- R3: A write to register address 0 (the request register) clears each request bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. A write never sets a request bit.
- R4: While `brk_req` is high, `irq_o` is high whatever `iflag` and the enable bits hold. Break is the lowest level, 16, and its vector low byte is 0xFFDC.
- R5: Request and enable bit k (0..14) belong to priority level k+1, and a lower level number wins. Bit order: 0 ext0, 1 ext1, 2 serial-1 receive, 3 serial-1 transmit, 4 timer X, 5 timer Y, 6 timer 1, 7 timer 2, 8 ext2, 9 ext3, 10 serial-2, 11 ext4, 12 ext5, 13 ext6, 14 converter done. Level 0 is reset and level 16 is break.
- R6: For winning level L, `vec_lo` = 0xFFFC - 2*L and `vec_hi` = `vec_lo` + 1.
- R7: With `irq_o` high, `ack` high produces `accept_o` high in the same cycle and clears the winner's request bit at that clock edge. Other pending bits stay set and are taken by later acknowledges.
- R8: Each external pin i has polarity bit i in register address 2. 0 selects the rising edge and 1 selects the falling edge. The pin is synchronized through two flops, and a detected edge sets the mapped request bit from R5.
- R9: Changing a polarity bit while its pin is steady can itself set that pin's request bit. The sequence disable, change polarity, clear request, re-enable leaves no request pending and `irq_o` low.
- R10: Event pulses for the serial-1 sources (`periph_evt[0]`, `periph_evt[1]`) set requests only while `ser1_on` is 1. The serial-2 pulse (`periph_evt[6]`) sets its request only while `ser2_on` is 1.
- R11: `periph_evt[j]` sets request bit 2,3,4,5,6,7,10,14 for j = 0..7 respectively, one clock edge after the pulse. Register address 1 holds the enable bits, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 7 | Asynchronous external request pins |
| periph_evt | input | 8 | One-cycle internal event pulses |
| ser1_on | input | 1 | Serial-1 function selected |
| ser2_on | input | 1 | Serial-2 function selected |
| brk_req | input | 1 | Break request from the core, held until taken |
| iflag | input | 1 | Core interrupt-disable flag |
| ack | input | 1 | Core acknowledge, one cycle |
| irq_o | output | 1 | An allowed source is pending |
| accept_o | output | 1 | Acknowledge taken; core sets its disable flag |
| vec_lo | output | 16 | Address of vector low byte |
| vec_hi | output | 16 | Address of vector high byte |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The bench builds the block with its default parameters: a 16-bit vector space topped at 0xFFFC and a two-stage synchronizer. These values put every entry of the seventeen-level vector table within reach, from reset down to break. They also give a fixed delay from a pin change to its request bit, which the bench waits out before it reads. With this build, polarity writes can be made against steady pins, so both the spurious request and the safe reprogramming sequence can be observed through the request register.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NUM_MASK = 15;
    localparam int NUM_EXT  = 7;
    localparam int NUM_EVT  = 8;
    localparam int NUM_LVL  = NUM_MASK + 2;
    localparam int LVL_W    = $clog2(NUM_LVL);

    typedef struct packed {
        logic                rst_pend;
        logic [NUM_MASK-1:0] req;
        logic [NUM_MASK-1:0] en;
        logic [NUM_EXT-1:0]  pol;
    } ctl_t;

    // request bit fed by external pin i
    function automatic int ext_slot(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 8;
            3: return 9;
            4: return 11;
            5: return 12;
            default: return 13;
        endcase
    endfunction

    // request bit fed by event pulse j
    function automatic int evt_slot(int j);
        case (j)
            0: return 2;
            1: return 3;
            2: return 4;
            3: return 5;
            4: return 6;
            5: return 7;
            6: return 10;
            default: return 14;
        endcase
    endfunction

    // 0: always valid, 1: needs serial-1, 2: needs serial-2
    function automatic int evt_gate(int j);
        case (j)
            0, 1: return 1;
            6: return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              eff;
    } edge_st_t;

    edge_st_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin_i};
        d.eff  = q.sync[STAGES-1] ^ pol_i;
        edge_o = d.eff & ~q.eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int                NUM_LVL = 17,
    parameter int                LVL_W   = 5,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] VEC_TOP = 16'hFFFC
) (
    input  logic [NUM_LVL-1:0] pend,
    output logic               any_o,
    output logic [LVL_W-1:0]   win_o,
    output logic [ADDR_W-1:0]  vec_lo_o,
    output logic [ADDR_W-1:0]  vec_hi_o
);
    logic [NUM_LVL-1:0] low_mask;

    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_o = LVL_W'(i);
                any_o = 1'b1;
            end
        end
        vec_lo_o = VEC_TOP - ADDR_W'({win_o, 1'b0});
        vec_hi_o = vec_lo_o + ADDR_W'(1);
        low_mask = (NUM_LVL'(1) << win_o) - NUM_LVL'(1);
    end

    // R5
    always_comb begin
        prio_win_chk: assert (!any_o || (pend[win_o] && ((pend & low_mask) == '0)));
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] VEC_TOP     = 16'hFFFC,
    parameter int                SYNC_STAGES = 2,
    parameter int                DATA_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXT-1:0]  ext_pin,
    input  logic [NUM_EVT-1:0]  periph_evt,
    input  logic                ser1_on,
    input  logic                ser2_on,
    input  logic                brk_req,
    input  logic                iflag,
    input  logic                ack,
    output logic                irq_o,
    output logic                accept_o,
    output logic [ADDR_W-1:0]   vec_lo,
    output logic [ADDR_W-1:0]   vec_hi,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam int BRK_LVL = NUM_LVL - 1;

    ctl_t d, q;

    logic [NUM_EXT-1:0]  ext_edge;
    logic [NUM_MASK-1:0] hw_set;
    logic [NUM_MASK-1:0] ack_clr;
    logic [NUM_LVL-1:0]  pend;
    logic [LVL_W-1:0]    win;
    logic                any_pend;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        irq_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_pin[g]),
            .pol_i  (q.pol[g]),
            .edge_o (ext_edge[g])
        );
    end

    // hardware set vector: pin edges and gated event pulses
    always_comb begin
        hw_set = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (ext_edge[i]) hw_set[ext_slot(i)] = 1'b1;
        end
        for (int j = 0; j < NUM_EVT; j++) begin
            if (periph_evt[j] &&
                ((evt_gate(j) == 0) || (evt_gate(j) == 1 && ser1_on) ||
                 (evt_gate(j) == 2 && ser2_on)))
                hw_set[evt_slot(j)] = 1'b1;
        end
    end

    always_comb begin
        pend[0]       = q.rst_pend;
        pend[BRK_LVL] = brk_req;
        for (int k = 0; k < NUM_MASK; k++) begin
            pend[k+1] = q.req[k] & q.en[k] & ~iflag;
        end
    end

    irq_prio_enc #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W),
        .ADDR_W  (ADDR_W),
        .VEC_TOP (VEC_TOP)
    ) u_enc (
        .pend     (pend),
        .any_o    (any_pend),
        .win_o    (win),
        .vec_lo_o (vec_lo),
        .vec_hi_o (vec_hi)
    );

    assign irq_o    = any_pend;
    assign accept_o = ack & any_pend;

    always_comb begin
        d = q;
        for (int k = 0; k < NUM_MASK; k++) begin
            ack_clr[k] = accept_o && (int'(win) == k + 1);
        end
        if (accept_o && win == '0) d.rst_pend = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                2'd0:    d.req = q.req & reg_wdata[NUM_MASK-1:0];
                2'd1:    d.en  = reg_wdata[NUM_MASK-1:0];
                2'd2:    d.pol = reg_wdata[NUM_EXT-1:0];
                default: ;
            endcase
        end
        d.req = (d.req & ~ack_clr) | hw_set;
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = DATA_W'(q.req);
            2'd1:    reg_rdata = DATA_W'(q.en);
            2'd2:    reg_rdata = DATA_W'(q.pol);
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.rst_pend <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R1
    rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_pend |-> (irq_o && vec_lo == VEC_TOP));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iflag && !brk_req && !q.rst_pend) |-> !irq_o);

    // R3
    sw_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q.req & ~$past(q.req) & ~$past(hw_set)) == '0));

    // R4
    brk_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> irq_o);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> ((q.req & $past(ack_clr & ~hw_set)) == '0));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ext_pin = '0;
    logic [7:0]  periph_evt = '0;
    logic        ser1_on = 1'b0;
    logic        ser2_on = 1'b0;
    logic        brk_req = 1'b0;
    logic        iflag = 1'b0;
    logic        ack = 1'b0;
    logic        irq_o, accept_o;
    logic [15:0] vec_lo, vec_hi;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    logic [15:0] exp_v;
    logic [15:0] rv;

    always #4 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .periph_evt(periph_evt),
        .ser1_on(ser1_on), .ser2_on(ser2_on), .brk_req(brk_req), .iflag(iflag),
        .ack(ack), .irq_o(irq_o), .accept_o(accept_o), .vec_lo(vec_lo),
        .vec_hi(vec_hi), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(logic [7:0] m);
        @(negedge clk);
        periph_evt = m;
        @(negedge clk);
        periph_evt = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic peek(string tag, logic exp_irq, logic [15:0] exp_lo);
        @(negedge clk);
        #1;
        chk(tag, irq_o, exp_irq);
        if (exp_irq) chk(tag, vec_lo, exp_lo);
    endtask

    // driver: pushes the expected vector and pulses ack for one cycle
    task automatic take(string tag, logic [15:0] exp_lo);
        @(negedge clk);
        chk(tag, irq_o, 1'b1);
        exp_q.push_back(exp_lo);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // monitor: compares the presented vector against the scoreboard
    always @(negedge clk) begin
        #3;
        if (ack) begin
            if (exp_q.size() == 0) begin
                chk("R6 scoreboard empty", 32'd1, 32'd0);
            end else begin
                exp_v = exp_q.pop_front();
                chk("R6 vec_lo", vec_lo, exp_v);
                chk("R6 vec_hi", vec_hi, exp_v + 16'd1);
                chk("R7 accept_o", accept_o, 1'b1);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, rv); chk("R1 req", rv, 16'h0);
        rd(2'd1, rv); chk("R1 en", rv, 16'h0);
        rd(2'd2, rv); chk("R1 pol", rv, 16'h0);
        peek("R1 reset pending", 1'b1, 16'hFFFC);
        take("R1 ack", 16'hFFFC);
        peek("R1 after ack", 1'b0, 16'h0);
        rd(2'd3, rv); chk("R11 addr3", rv, 16'h0);

        // R2 / R11: timer X event held off by iflag
        iflag = 1'b1;
        wr(2'd1, 16'h7FFF);
        rd(2'd1, rv); chk("R11 en reg", rv, 16'h7FFF);
        pulse(8'h04);
        peek("R2 iflag masks", 1'b0, 16'h0);
        rd(2'd0, rv); chk("R11 timer X bit", rv, 16'h0010);
        iflag = 1'b0;
        peek("R2 unmasked", 1'b1, 16'hFFF2);
        take("R7 timer X", 16'hFFF2);
        rd(2'd0, rv); chk("R7 cleared", rv, 16'h0);

        // R3: software cannot set, only clear
        wr(2'd0, 16'hFFFF);
        rd(2'd0, rv); chk("R3 no set", rv, 16'h0);
        iflag = 1'b1;
        pulse(8'h10);
        pulse(8'h80);
        wr(2'd0, 16'hFFBF);
        rd(2'd0, rv); chk("R3 clear one", rv, 16'h4000);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); chk("R3 clear all", rv, 16'h0);
        iflag = 1'b0;

        // R5 / R7: simultaneous timer Y and converter done
        pulse(8'h88);
        take("R5 timer Y first", 16'hFFF0);
        rd(2'd0, rv); chk("R7 lower stays", rv, 16'h4000);
        take("R5 converter", 16'hFFDE);
        rd(2'd0, rv); chk("R7 both taken", rv, 16'h0);

        // R2: enable bit masks
        wr(2'd1, 16'h7FDF);
        pulse(8'h08);
        peek("R2 enable off", 1'b0, 16'h0);
        rd(2'd0, rv); chk("R2 latched while masked", rv, 16'h0020);
        wr(2'd1, 16'h7FFF);
        peek("R2 enable on", 1'b1, 16'hFFF0);
        wr(2'd0, 16'h0000);
        peek("R3 cleared pending", 1'b0, 16'h0);

        // R4: break ignores all masks, lowest level
        iflag = 1'b1;
        wr(2'd1, 16'h0000);
        brk_req = 1'b1;
        peek("R4 break unmasked", 1'b1, 16'hFFDC);
        take("R4 break", 16'hFFDC);
        brk_req = 1'b0;
        iflag = 1'b0;
        wr(2'd1, 16'h7FFF);
        pulse(8'h04);
        brk_req = 1'b1;
        take("R4 timer X beats break", 16'hFFF2);
        take("R4 break last", 16'hFFDC);
        brk_req = 1'b0;
        peek("R4 idle", 1'b0, 16'h0);

        // R8: rising edge on ext0
        @(negedge clk); ext_pin[0] = 1'b1;
        idle(4);
        rd(2'd0, rv); chk("R8 rising sets", rv, 16'h0001);
        take("R8 ext0", 16'hFFFA);
        @(negedge clk); ext_pin[0] = 1'b0;
        idle(4);
        rd(2'd0, rv); chk("R8 falling ignored", rv, 16'h0);

        // R9: polarity change on steady ext2 raises a request
        wr(2'd2, 16'h0004);
        idle(4);
        rd(2'd0, rv); chk("R9 spurious edge", rv, 16'h0100);
        wr(2'd0, 16'h0000);
        // R8: falling polarity on ext2
        @(negedge clk); ext_pin[2] = 1'b1;
        idle(4);
        rd(2'd0, rv); chk("R8 rising ignored", rv, 16'h0);
        @(negedge clk); ext_pin[2] = 1'b0;
        idle(4);
        rd(2'd0, rv); chk("R8 falling sets", rv, 16'h0100);
        take("R8 ext2", 16'hFFEA);

        // R9: safe reprogramming sequence on ext4
        wr(2'd1, 16'h77FF);
        wr(2'd2, 16'h0014);
        idle(4);
        wr(2'd0, 16'hF7FF);
        wr(2'd1, 16'h7FFF);
        idle(4);
        rd(2'd0, rv); chk("R9 safe sequence", rv, 16'h0);
        peek("R9 no irq", 1'b0, 16'h0);

        // R10: serial gating
        pulse(8'h01);
        rd(2'd0, rv); chk("R10 ser1 off", rv, 16'h0);
        pulse(8'h40);
        rd(2'd0, rv); chk("R10 ser2 off", rv, 16'h0);
        ser1_on = 1'b1;
        pulse(8'h01);
        rd(2'd0, rv); chk("R10 ser1 on", rv, 16'h0004);
        take("R10 ser1 rx", 16'hFFF6);
        ser2_on = 1'b1;
        pulse(8'h40);
        rd(2'd0, rv); chk("R11 ser2 bit", rv, 16'h0400);
        take("R10 ser2", 16'hFFE6);
        peek("R7 all taken", 1'b0, 16'h0);

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule